// File: doc/BRIEF.md
# Chip-wide reset and power-down controller

This block owns the few control bits that act on the whole chip: a self-clearing software reset, a power-down request, a bit that decides whether the power-down pin or the power-down register bit is obeyed, and the driver-disable controls for the video data, timing and line-clock outputs. It merges those bits with an active-low external reset pin and an active-low power-down pin, both synchronised into the controller clock domain, and produces a clock enable for the digital core, a low-current flag for the analog sections, three output-enable signals and a busy flag.

A reset, from the register bit or the pin, starts a timed sequence of `RST_CYCLES` clock cycles. While it runs, the host register port refuses every access with a not-acknowledge. Bits that have a defined default go back to it at the start of the sequence. A group of scratch bits has no defined default and keeps its last written value. A one-cycle done pulse marks the first cycle after the sequence. Power-down gates only the core clock enable. The register port keeps working throughout, so power-down can be left by writing the request bit back to 0.

The host side is a parallel request port. Each request gets exactly one response, on the cycle after it is presented. A write takes effect on that same edge.

Top module: `glob_pwr_rst_ctrl`

## Requirements
- R1: After `por_n` reset, registers 0x0F, 0x03 and 0x1D read 0x00, `busy` and `rst_done` are 0, and all three output enables are 1.
- R2: An accepted write to address 0x0F with bit 7 set makes `busy` 1 for exactly `RST_CYCLES` cycles, starting at the edge that accepts the write. `rst_done` is 1 for exactly one cycle: the first cycle in which `busy` is 0 again.
- R3: A request presented while `busy` is 1 gets `host_nack`=1 and `host_ack`=0 on the next cycle, and a write refused this way changes no register.
- R4: When a sequence starts, 0x0F bit 5 (power-down request), 0x0F bit 2 (priority), 0x03 bit 6, 0x03 bit 5 and 0x1D bit 7 return to 0. Bit 7 of 0x0F is never stored and always reads 0.
- R5: Register 0x03 bits 7, 4, 3, 2, 1 and 0 keep their written value through software and pin resets. Only `por_n` clears them.
- R6: After its two-flop synchroniser, `ext_rst_n` low has the same effect as the software reset and holds `busy` at 1. After release, `busy` stays 1 for `RST_CYCLES`+1 more sampled cycles, and then `rst_done` pulses.
- R7: With the priority bit at 0, `core_clk_en` equals `pin_pd_n`, two clock edges after that pin changes, and 0x0F bit 5 has no effect.
- R8: With the priority bit at 1, `core_clk_en` is the inverse of 0x0F bit 5, and `pin_pd_n` has no effect.
- R9: `analog_lowpwr` is always the inverse of `core_clk_en`.
- R10: 0x03 bit 6 at 1 drives `data_oe` to 0 and also drives `timing_oe` to 0 unless R11 applies.
- R11: 0x03 bit 5 at 1 holds `timing_oe` at 1 whatever the value of 0x03 bit 6.
- R12: 0x1D bit 7 at 1 drives `line_clk_oe` to 0.
- R13: When `busy` is 0, a request gets `host_ack`=1 on the next cycle, and a read returns the register value in `host_rdata` in that same cycle. This holds while powered down too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| pin_pd_n | input | 1 | External power-down pin, active low, asynchronous to clk |
| host_req | input | 1 | Host access request, one cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_ack |
| host_ack | output | 1 | Access accepted |
| host_nack | output | 1 | Access refused (reset sequence running) |
| core_clk_en | output | 1 | Clock enable for the digital core |
| analog_lowpwr | output | 1 | Low-current mode request for the analog sections |
| data_oe | output | 1 | Enable for the data, sync, field and lock output drivers |
| timing_oe | output | 1 | Enable for the sync and field output drivers |
| line_clk_oe | output | 1 | Enable for the line-clock output driver |
| busy | output | 1 | Reset sequence running |
| rst_done | output | 1 | One-cycle pulse after the sequence ends |

## Verification
The bench builds the controller with `RST_CYCLES` set to 24 and the synchroniser depth left at 2. A full sequence therefore lasts only a few dozen cycles. This makes it practical to count the busy window to the exact cycle for both the software and the pin reset, to fire refused accesses into the middle of it, and to run several complete sequences inside a random register and pin workload. The default cycle count corresponds to a multi-millisecond wait and would leave room for only one or two sequences per run.

// File: rtl/prc_pkg.sv
// Package: register addresses, bit positions and the control-bit bundle
// shared by the reset/power-down controller modules.
package prc_pkg;

    localparam logic [7:0] ADDR_GLOBAL = 8'h0F;
    localparam logic [7:0] ADDR_PINCTL = 8'h03;
    localparam logic [7:0] ADDR_LCLK   = 8'h1D;

    localparam int GLB_RST_BIT    = 7;
    localparam int GLB_PD_BIT     = 5;
    localparam int GLB_PRIO_BIT   = 2;
    localparam int PIN_OFF_BIT    = 6;
    localparam int PIN_TFORCE_BIT = 5;
    localparam int LCLK_OFF_BIT   = 7;

    localparam int KEEP_W = 6;

    typedef struct packed {
        logic              pd_req;
        logic              pd_prio;
        logic              out_off;
        logic              tim_force;
        logic              lclk_off;
        logic [KEEP_W-1:0] keep;
    } ctrl_t;

endpackage

// File: rtl/prc_sync.sv
// prc_sync: multi-flop synchroniser for one asynchronous level input.
// Assumes the input is a slow level (pin) and that STAGES >= 2.
// The flops load RST_VAL on por_n so that the pin reads as inactive.
module prc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!por_n) begin
                    chain[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/prc_rst_seq.sv
// prc_rst_seq: timed reset sequencer.
// A start pulse (or a held start level) loads the down-counter. busy is
// high while the counter runs. done pulses in the first idle cycle.
// Assumes RST_CYCLES >= 2.
module prc_rst_seq #(
    parameter int RST_CYCLES = 250000
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          active;
    logic          done_q;

    // Load on start, count down while active, end at zero.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            active <= 1'b0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= LOAD;
            done_q <= 1'b0;
        end else begin
            done_q <= active && (cnt == '0);
            if (active) begin
                if (cnt == '0) begin
                    active <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    assign busy = active;
    assign done = done_q;

    // R2: the done pulse lasts one cycle.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!por_n)
        done |=> !done);

    // R2: done marks the first cycle after busy falls.
    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!por_n)
        $fell(busy) |-> done);

endmodule

// File: rtl/prc_regfile.sv
// prc_regfile: the three control registers.
// restore puts every defined-default bit back to 0 and has priority over
// a write. Keep bits are cleared only by por_n. The reset bit is never
// stored. Reads are combinational; the top registers the result.
module prc_regfile
    import prc_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        restore,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output ctrl_t       ctrl,
    output logic [7:0]  rdata
);

    // Defined-default bits: restore, then write.
    always_ff @(posedge clk) begin
        if (!por_n || restore) begin
            ctrl.pd_req    <= 1'b0;
            ctrl.pd_prio   <= 1'b0;
            ctrl.out_off   <= 1'b0;
            ctrl.tim_force <= 1'b0;
            ctrl.lclk_off  <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_GLOBAL) begin
                ctrl.pd_req  <= wdata[GLB_PD_BIT];
                ctrl.pd_prio <= wdata[GLB_PRIO_BIT];
            end
            if (addr == ADDR_PINCTL) begin
                ctrl.out_off   <= wdata[PIN_OFF_BIT];
                ctrl.tim_force <= wdata[PIN_TFORCE_BIT];
            end
            if (addr == ADDR_LCLK) begin
                ctrl.lclk_off <= wdata[LCLK_OFF_BIT];
            end
        end
    end

    // Keep bits: survive restore, cleared only at power-on.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ctrl.keep <= '0;
        end else if (wr_en && !restore && addr == ADDR_PINCTL) begin
            ctrl.keep <= {wdata[7], wdata[4:0]};
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = 8'h00;
        case (addr)
            ADDR_GLOBAL: begin
                rdata[GLB_PD_BIT]   = ctrl.pd_req;
                rdata[GLB_PRIO_BIT] = ctrl.pd_prio;
            end
            ADDR_PINCTL: begin
                rdata = {ctrl.keep[5], ctrl.out_off, ctrl.tim_force, ctrl.keep[4:0]};
            end
            ADDR_LCLK: begin
                rdata[LCLK_OFF_BIT] = ctrl.lclk_off;
            end
            default: rdata = 8'h00;
        endcase
    end

    // R4: a restore leaves every defined-default bit at 0.
    a_r4_restore_defaults: assert property (@(posedge clk) disable iff (!por_n)
        restore |=> !ctrl.pd_req && !ctrl.pd_prio && !ctrl.out_off
                    && !ctrl.tim_force && !ctrl.lclk_off);

    // R5: a restore never touches the keep bits.
    a_r5_keep_survives: assert property (@(posedge clk) disable iff (!por_n)
        restore |=> $stable(ctrl.keep));

endmodule

// File: rtl/glob_pwr_rst_ctrl.sv
// glob_pwr_rst_ctrl: chip-wide reset and power-down controller (top).
// Combines the synchronised reset and power-down pins with the register
// bits. It drives the core clock enable, the analog low-current flag and
// the output enables, and refuses host accesses while a reset sequence
// runs. Assumes one request at a most per cycle and one response per
// request on the following cycle.
module glob_pwr_rst_ctrl
    import prc_pkg::*;
#(
    parameter int RST_CYCLES  = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic       pin_pd_n,
    input  logic       host_req,
    input  logic       host_we,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_ack,
    output logic       host_nack,
    output logic       core_clk_en,
    output logic       analog_lowpwr,
    output logic       data_oe,
    output logic       timing_oe,
    output logic       line_clk_oe,
    output logic       busy,
    output logic       rst_done
);

    logic       ext_rst_s;
    logic       pin_pd_s;
    logic       accept;
    logic       soft_rst;
    logic       seq_start;
    logic       pd_eff;
    logic [7:0] rd_mux;
    ctrl_t      ctrl;

    prc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
        .clk(clk), .por_n(por_n), .d_async(ext_rst_n), .q_sync(ext_rst_s));

    prc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pd (
        .clk(clk), .por_n(por_n), .d_async(pin_pd_n), .q_sync(pin_pd_s));

    // A request is taken only while no sequence runs.
    assign accept    = host_req && !busy;
    assign soft_rst  = accept && host_we && (host_addr == ADDR_GLOBAL)
                       && host_wdata[GLB_RST_BIT];
    assign seq_start = soft_rst || !ext_rst_s;

    prc_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk(clk), .por_n(por_n), .start(seq_start),
        .busy(busy), .done(rst_done));

    prc_regfile u_regs (
        .clk(clk), .por_n(por_n), .restore(seq_start),
        .wr_en(accept && host_we), .addr(host_addr), .wdata(host_wdata),
        .ctrl(ctrl), .rdata(rd_mux));

    // Host response: ack or nack one cycle after each request.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            host_ack   <= 1'b0;
            host_nack  <= 1'b0;
            host_rdata <= 8'h00;
        end else begin
            host_ack   <= accept;
            host_nack  <= host_req && busy;
            host_rdata <= (accept && !host_we) ? rd_mux : 8'h00;
        end
    end

    // Power-down source selected by the priority bit.
    assign pd_eff        = ctrl.pd_prio ? ctrl.pd_req : !pin_pd_s;
    assign core_clk_en   = !pd_eff;
    assign analog_lowpwr = pd_eff;

    // Output driver enables.
    assign data_oe     = !ctrl.out_off;
    assign timing_oe   = !ctrl.out_off || ctrl.tim_force;
    assign line_clk_oe = !ctrl.lclk_off;

    // R3: a request during a sequence is refused on the next cycle.
    a_r3_nack_busy: assert property (@(posedge clk) disable iff (!por_n)
        host_req && busy |=> host_nack && !host_ack);

    // R13: the two responses never appear together.
    a_r13_resp_excl: assert property (@(posedge clk) disable iff (!por_n)
        !(host_ack && host_nack));

    // R9: clock enable and low-current flag stay complementary.
    a_r9_lowpwr_pair: assert property (@(posedge clk) disable iff (!por_n)
        core_clk_en != analog_lowpwr);

    // R11: the force bit keeps the timing drivers on.
    a_r11_tim_force: assert property (@(posedge clk) disable iff (!por_n)
        ctrl.tim_force |-> timing_oe);

    // R10: the data drivers stay on while the bulk disable bit is 0.
    a_r10_data_on: assert property (@(posedge clk) disable iff (!por_n)
        !ctrl.out_off |-> data_oe);

    // R6: the pin reset keeps the sequencer busy one cycle later.
    a_r6_pin_busy: assert property (@(posedge clk) disable iff (!por_n)
        !ext_rst_s |=> busy);

endmodule

// File: tb/glob_pwr_rst_ctrl_tb_top.sv
module glob_pwr_rst_ctrl_tb_top;

    localparam int N = 24;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       pin_pd_n = 1'b1;
    logic       host_req = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_ack, host_nack, core_clk_en, analog_lowpwr;
    logic       data_oe, timing_oe, line_clk_oe, busy, rst_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // model state
    bit       m_pd, m_prio, m_off, m_force, m_lclk;
    bit [5:0] m_keep;
    bit       m_pin;

    always #4 clk = ~clk;

    glob_pwr_rst_ctrl #(.RST_CYCLES(N), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .pin_pd_n(pin_pd_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
        .host_nack(host_nack), .core_clk_en(core_clk_en),
        .analog_lowpwr(analog_lowpwr), .data_oe(data_oe), .timing_oe(timing_oe),
        .line_clk_oe(line_clk_oe), .busy(busy), .rst_done(rst_done));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit [7:0] exp_read(input bit [7:0] a);
        case (a)
            8'h0F:   return {2'b00, m_pd, 2'b00, m_prio, 2'b00};
            8'h03:   return {m_keep[5], m_off, m_force, m_keep[4:0]};
            8'h1D:   return {m_lclk, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit exp_clk_en();
        return m_prio ? !m_pd : m_pin;
    endfunction

    task automatic model_defaults();
        m_pd = 0; m_prio = 0; m_off = 0; m_force = 0; m_lclk = 0;
    endtask

    task automatic model_write(input bit [7:0] a, input bit [7:0] d);
        if (a == 8'h0F) begin m_pd = d[5]; m_prio = d[2]; end
        if (a == 8'h03) begin m_off = d[6]; m_force = d[5]; m_keep = {d[7], d[4:0]}; end
        if (a == 8'h1D) m_lclk = d[7];
    endtask

    // one access; ends at the negedge where the response is visible
    task automatic access(input bit we, input bit [7:0] a, input bit [7:0] d);
        host_req = 1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 0; host_we = 0;
    endtask

    task automatic check_outputs(input string tag);
        check(core_clk_en == exp_clk_en(), {tag, " R7/R8 clk_en"}, core_clk_en, exp_clk_en());
        check(analog_lowpwr == !exp_clk_en(), {tag, " R9 lowpwr"}, analog_lowpwr, !exp_clk_en());
        check(data_oe == !m_off, {tag, " R10 data_oe"}, data_oe, !m_off);
        check(timing_oe == (!m_off || m_force), {tag, " R11 timing_oe"}, timing_oe, !m_off || m_force);
        check(line_clk_oe == !m_lclk, {tag, " R12 line_clk_oe"}, line_clk_oe, !m_lclk);
    endtask

    task automatic read_check(input bit [7:0] a, input string tag);
        access(0, a, 8'h00);
        check(host_ack && !host_nack, {tag, " R13 ack"}, host_ack, 1);
        check(host_rdata == exp_read(a), {tag, " R13 rdata"}, host_rdata, exp_read(a));
    endtask

    task automatic wait_idle_count(inout int cnt);
        int guard = 0;
        while (busy && guard < 10 * N) begin
            @(negedge clk);
            guard++;
            if (busy) cnt++;
        end
    endtask

    task automatic soft_reset(input bit [7:0] extra);
        int cnt = 0;
        access(1, 8'h0F, 8'h80 | extra);
        check(host_ack, "R2 reset write acked", host_ack, 1);
        if (busy) cnt++;
        model_defaults();
        access(1, 8'h1D, 8'h80);
        check(host_nack && !host_ack, "R3 write nack", {host_nack, host_ack}, 2);
        if (busy) cnt++;
        access(0, 8'h03, 8'h00);
        check(host_nack && !host_ack, "R3 read nack", {host_nack, host_ack}, 2);
        if (busy) cnt++;
        wait_idle_count(cnt);
        check(cnt == N, "R2 busy length", cnt, N);
        check(rst_done == 1, "R2 done pulse", rst_done, 1);
        @(negedge clk);
        check(rst_done == 0, "R2 done single", rst_done, 0);
        check_outputs("R3 R4 after soft reset");
        read_check(8'h0F, "R4 0x0F");
        read_check(8'h03, "R5 keep");
        read_check(8'h1D, "R3 refused write");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        por_n = 1;
        @(negedge clk);
        m_pin = 1; m_keep = 0; model_defaults();
        check(busy == 0 && rst_done == 0, "R1 idle", {busy, rst_done}, 0);
        check_outputs("R1");
        read_check(8'h0F, "R1");
        read_check(8'h03, "R1");
        read_check(8'h1D, "R1");

        // directed output-enable corners
        access(1, 8'h03, 8'h40); model_write(8'h03, 8'h40); check_outputs("R10 off");
        access(1, 8'h03, 8'h60); model_write(8'h03, 8'h60); check_outputs("R11 force");
        access(1, 8'h03, 8'h20); model_write(8'h03, 8'h20); check_outputs("R11 force only");
        access(1, 8'h1D, 8'h80); model_write(8'h1D, 8'h80); check_outputs("R12");

        // priority 0: register bit ignored, pin obeyed
        access(1, 8'h0F, 8'h20); model_write(8'h0F, 8'h20); check_outputs("R7 reg ignored");
        pin_pd_n = 0; m_pin = 0;
        @(negedge clk);
        check(core_clk_en == 1, "R7 one edge", core_clk_en, 1);
        @(negedge clk);
        check_outputs("R7 pin pd");
        read_check(8'h1D, "R13 regs live in pd");
        // priority 1: pin ignored
        access(1, 8'h0F, 8'h04); model_write(8'h0F, 8'h04); check_outputs("R8 reg 0");
        access(1, 8'h0F, 8'h24); model_write(8'h0F, 8'h24); check_outputs("R8 reg 1");
        pin_pd_n = 1; m_pin = 1;
        repeat (3) @(negedge clk);
        check_outputs("R8 pin ignored");

        // keep bits set, then software reset ends power-down
        access(1, 8'h03, 8'h9B); model_write(8'h03, 8'h9B);
        soft_reset(8'h24);

        // pin reset during register power-down
        access(1, 8'h0F, 8'h24); model_write(8'h0F, 8'h24);
        access(1, 8'h03, 8'h7F); model_write(8'h03, 8'h7F);
        check_outputs("R6 pre");
        ext_rst_n = 0;
        repeat (3) @(negedge clk);
        check(busy == 1, "R6 busy while pin low", busy, 1);
        model_defaults();
        check_outputs("R6 power-down ended");
        access(1, 8'h1D, 8'h80);
        check(host_nack, "R6 R3 nack under pin", host_nack, 1);
        begin
            int cnt = 0;
            ext_rst_n = 1;
            @(negedge clk);
            if (busy) cnt++;
            wait_idle_count(cnt);
            check(cnt == N + 1, "R6 busy after release", cnt, N + 1);
            check(rst_done == 1, "R6 done", rst_done, 1);
        end
        @(negedge clk);
        read_check(8'h03, "R5 keep after pin");
        read_check(8'h1D, "R6 refused write");

        // constrained random workload
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            bit [7:0] a;
            bit [7:0] d = 8'($urandom);
            case ($urandom_range(0, 3))
                0: a = 8'h0F; 1: a = 8'h03; 2: a = 8'h1D; default: a = 8'($urandom);
            endcase
            if (a == 8'h0F) d[7] = 0;
            if (op < 5) begin
                access(1, a, d);
                check(host_ack, "R13 random write ack", host_ack, 1);
                model_write(a, d);
                check_outputs("R10 random");
            end else if (op < 8) begin
                read_check(a, "R13 random read");
            end else if (op == 8) begin
                pin_pd_n = ~pin_pd_n; m_pin = pin_pd_n;
                repeat (2) @(negedge clk);
                check_outputs("R7 random pin");
            end else if ($urandom_range(0, 9) == 0) begin
                soft_reset(d);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule